// File: doc/BRIEF.md
# Peripheral-to-pin remapping crossbar

This block sits between a set of digital peripherals and a fixed group of remappable I/O pads. Routing runs in two directions, and each direction has its own bank of mapping registers. Each peripheral input has a select register that holds the number of the pad that feeds it. Each pad has a code register that names the peripheral output driving it. Because the two banks are separate, a peripheral's input and its output can sit on any two pads.

A remappable peripheral has no default pad. An unmapped input sees its inactive level, and an unmapped output drives nothing. Each pad has a priority arbiter. An analog function on the pad always wins. Below it comes a mapped peripheral, then a fixed (non-remappable) digital function, then plain GPIO.

Software reaches the banks through a simple write/read register port. A lock bit guards both banks. The lock can be set at any time. Clearing it takes a three-write key sequence on consecutive clock cycles.

Register map at the defaults:

| Address | Register |
|---|---|
| 0x00 | lock control (bit 0 is the lock) |
| 0x01 | key register |
| 0x20 + i | select register of peripheral input i |
| 0x40 + p | code register of pad p |

Top module: `pinmux_xbar`

## Requirements
- R1: After reset, every select register reads 0x1F (unmapped), every code register reads 0x00, and the lock register at 0x00 reads 0.
- R2: While unlocked, a write to 0x20+i stores the low 5 bits of the data in select register i, and a write to 0x40+p stores the low 4 bits in code register p. The stored value reads back at the same address on the cycle after the write. Unused addresses, including the key register 0x01, read 0.
- R3: Peripheral input i carries the digital input of pad N, where N is the value in select register i and N < 22. Several inputs may share one pad.
- R4: When select register i holds a value of 22 or more, peripheral input i is tied to its inactive level, which is 1 at the defaults.
- R5: When pad p is not analog and its code c is in the range 1 to 12, the pad's output value and output enable come from peripheral output c-1. This overrides the fixed digital function and GPIO.
- R6: A code of 0, or of 13 to 15, gives the pad no peripheral. The pad then takes its fixed digital function when that function's enable is set, and GPIO otherwise.
- R7: While a pad's analog enable is set, the pad's output enable and output value are 0. The digital input that pad offers to the peripheral inputs also reads 0, whatever the pad's code.
- R8: Writing data with bit 0 set to 0x00 sets the lock at any time. While the lock is set, writes to both mapping banks are ignored.
- R9: The lock clears only through three writes on consecutive cycles: 0x55 to 0x01, then 0xAA to 0x01, then data with bit 0 clear to 0x00. Any other order, or a gap between the writes, leaves the lock set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| wrEn | input | 1 | register write strobe |
| wrAddr | input | 8 | write address |
| wrData | input | 8 | write data |
| rdAddr | input | 8 | read address |
| rdData | output | 8 | read data, combinational from rdAddr |
| padIn | input | 22 | digital level sensed on each pad |
| anaEn | input | 22 | analog function enable per pad |
| gpioOut | input | 22 | GPIO output value per pad |
| gpioOe | input | 22 | GPIO output enable per pad |
| altEn | input | 22 | fixed digital function active per pad |
| altOut | input | 22 | fixed digital function output value |
| altOe | input | 22 | fixed digital function output enable |
| periphOut | input | 12 | remappable peripheral output values |
| periphOe | input | 12 | remappable peripheral output enables |
| periphIn | output | 8 | routed remappable peripheral inputs |
| padOut | output | 22 | output value to each pad |
| padOe | output | 22 | output enable to each pad |

## Verification
The first stimulus pattern sets every select register to a distinct pad while the pad levels change randomly each cycle. This tells correct routing apart from a crossed or stuck select. A second pattern makes several inputs share one pad and writes out-of-range selects, so a fixed inactive level can be told apart from a stale pad value.

For the output side, pads are loaded with every code, including codes above the last peripheral. The fixed-function and analog enables are toggled under each code, which separates each level of the priority order. Lock stimulus tries gapped, reordered and missing key writes before the correct sequence, so a lock that opens too easily is told apart from one that never opens.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  // register map of the write/read port
  localparam logic [7:0] ADDR_LOCK  = 8'h00;
  localparam logic [7:0] ADDR_KEY   = 8'h01;
  localparam logic [7:0] SEL_BASE   = 8'h20;
  localparam logic [7:0] CODE_BASE  = 8'h40;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    KEY_IDLE,
    KEY_GOT_FIRST,
    KEY_ARMED
  } key_state_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic       locked;
    logic       selWr;
    logic       codeWr;
    logic [7:0] idx;
    logic [7:0] data;
  } map_strobe_t;

endpackage

// File: rtl/pinmux_pin_arb.sv
module pinmux_pin_arb #(
  parameter int NUM_PERIPH_OUT = 12,
  parameter int CODE_W         = 4
) (
  input  logic [CODE_W-1:0]         code,
  input  logic                      anaEn,
  input  logic [NUM_PERIPH_OUT-1:0] periphOut,
  input  logic [NUM_PERIPH_OUT-1:0] periphOe,
  input  logic                      altEn,
  input  logic                      altOut,
  input  logic                      altOe,
  input  logic                      gpioOut,
  input  logic                      gpioOe,
  output logic                      padOut,
  output logic                      padOe
);
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_PERIPH_OUT);

  logic              codeValid;
  logic [CODE_W-1:0] srcIdx;

  assign codeValid = (code != '0) && (code <= LAST_CODE);
  assign srcIdx    = code - 1'b1;

  // analog > mapped peripheral > fixed digital function > GPIO
  always_comb begin
    padOut = gpioOut;
    padOe  = gpioOe;
    if (anaEn) begin
      padOut = 1'b0;
      padOe  = 1'b0;
    end else if (codeValid) begin
      padOut = periphOut[srcIdx];
      padOe  = periphOe[srcIdx];
    end else if (altEn) begin
      padOut = altOut;
      padOe  = altOe;
    end
  end

endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS      = 22,
  parameter int NUM_PERIPH_IN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [7:0]  wrData,
  output map_strobe_t strobe
);
  localparam logic [7:0] SEL_END  = 8'(SEL_BASE + NUM_PERIPH_IN);
  localparam logic [7:0] CODE_END = 8'(CODE_BASE + NUM_PINS);

  key_state_e keyQ, keyNext;
  logic       lockQ, lockNext;
  logic       hitKey, hitLock, hitSel, hitCode;

  assign hitKey  = wrEn && (wrAddr == ADDR_KEY);
  assign hitLock = wrEn && (wrAddr == ADDR_LOCK);
  assign hitSel  = wrEn && (wrAddr >= SEL_BASE) && (wrAddr < SEL_END);
  assign hitCode = wrEn && (wrAddr >= CODE_BASE) && (wrAddr < CODE_END);

  // key tracker: any cycle that breaks the sequence returns to idle
  always_comb begin
    keyNext = KEY_IDLE;
    if (hitKey) begin
      if (wrData == KEY_FIRST) keyNext = KEY_GOT_FIRST;
      else if (wrData == KEY_SECOND && keyQ == KEY_GOT_FIRST) keyNext = KEY_ARMED;
    end
  end

  always_comb begin
    lockNext = lockQ;
    if (hitLock) begin
      if (wrData[0]) lockNext = 1'b1;
      else if (keyQ == KEY_ARMED) lockNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ  <= KEY_IDLE;
      lockQ <= 1'b0;
    end else begin
      keyQ  <= keyNext;
      lockQ <= lockNext;
    end
  end

  always_comb begin
    strobe.locked = lockQ;
    strobe.selWr  = hitSel && !lockQ;
    strobe.codeWr = hitCode && !lockQ;
    strobe.idx    = hitSel ? (wrAddr - SEL_BASE) : (wrAddr - CODE_BASE);
    strobe.data   = wrData;
  end

  // R9: the lock only drops right after a completed key
  assert_unlock_needs_key_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockQ) |-> $past(keyQ == KEY_ARMED));

  // R9: armed state only follows the first key and a second-key write
  assert_key_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    (keyQ == KEY_ARMED) |-> ($past(keyQ == KEY_GOT_FIRST) && $past(hitKey) && $past(wrData) == KEY_SECOND));

endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int                      NUM_PINS       = 22,
  parameter int                      NUM_PERIPH_IN  = 8,
  parameter int                      NUM_PERIPH_OUT = 12,
  parameter int                      SEL_W          = 5,
  parameter int                      CODE_W         = 4,
  parameter logic [NUM_PERIPH_IN-1:0] INACTIVE_LVL  = '1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  map_strobe_t               strobe,
  input  logic [7:0]                rdAddr,
  output logic [7:0]                rdData,
  input  logic [NUM_PINS-1:0]       padIn,
  input  logic [NUM_PINS-1:0]       anaEn,
  input  logic [NUM_PINS-1:0]       gpioOut,
  input  logic [NUM_PINS-1:0]       gpioOe,
  input  logic [NUM_PINS-1:0]       altEn,
  input  logic [NUM_PINS-1:0]       altOut,
  input  logic [NUM_PINS-1:0]       altOe,
  input  logic [NUM_PERIPH_OUT-1:0] periphOut,
  input  logic [NUM_PERIPH_OUT-1:0] periphOe,
  output logic [NUM_PERIPH_IN-1:0]  periphIn,
  output logic [NUM_PINS-1:0]       padOut,
  output logic [NUM_PINS-1:0]       padOe
);
  localparam logic [SEL_W-1:0]  PIN_LIMIT = SEL_W'(NUM_PINS);
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_PERIPH_OUT);

  logic [NUM_PERIPH_IN-1:0][SEL_W-1:0] selQ;
  logic [NUM_PINS-1:0][CODE_W-1:0]     codeQ;
  logic [NUM_PINS-1:0]                 digIn;

  // mapping banks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '1;
      codeQ <= '0;
    end else begin
      for (int i = 0; i < NUM_PERIPH_IN; i++)
        if (strobe.selWr && strobe.idx == 8'(i)) selQ[i] <= strobe.data[SEL_W-1:0];
      for (int p = 0; p < NUM_PINS; p++)
        if (strobe.codeWr && strobe.idx == 8'(p)) codeQ[p] <= strobe.data[CODE_W-1:0];
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_LOCK) rdData = {7'd0, strobe.locked};
    for (int i = 0; i < NUM_PERIPH_IN; i++)
      if (rdAddr == 8'(SEL_BASE + i)) rdData = 8'(selQ[i]);
    for (int p = 0; p < NUM_PINS; p++)
      if (rdAddr == 8'(CODE_BASE + p)) rdData = 8'(codeQ[p]);
  end

  // analog pads present 0 to the digital side
  assign digIn = padIn & ~anaEn;

  for (genvar i = 0; i < NUM_PERIPH_IN; i++) begin : g_in
    assign periphIn[i] = (selQ[i] < PIN_LIMIT) ? digIn[selQ[i]] : INACTIVE_LVL[i];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pinmux_pin_arb #(
      .NUM_PERIPH_OUT(NUM_PERIPH_OUT),
      .CODE_W        (CODE_W)
    ) i_arb (
      .code     (codeQ[p]),
      .anaEn    (anaEn[p]),
      .periphOut(periphOut),
      .periphOe (periphOe),
      .altEn    (altEn[p]),
      .altOut   (altOut[p]),
      .altOe    (altOe[p]),
      .gpioOut  (gpioOut[p]),
      .gpioOe   (gpioOe[p]),
      .padOut   (padOut[p]),
      .padOe    (padOe[p])
    );

    // R5: a valid code hands the pad to its peripheral
    assert_mapped_owns_pad_R5: assert property (@(posedge clk) disable iff (!rstN)
      (!anaEn[p] && codeQ[p] != '0 && codeQ[p] <= LAST_CODE) |->
        (padOut[p] == periphOut[codeQ[p] - 1'b1] && padOe[p] == periphOe[codeQ[p] - 1'b1]));

    // R6: no peripheral and no fixed function leaves GPIO in charge
    assert_gpio_fallback_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!anaEn[p] && !altEn[p] && (codeQ[p] == '0 || codeQ[p] > LAST_CODE)) |->
        (padOut[p] == gpioOut[p] && padOe[p] == gpioOe[p]));
  end

  // R7: analog pads are never driven digitally
  assert_analog_pad_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (anaEn & (padOe | padOut)) == '0);

  // R8: a locked cycle leaves both banks unchanged
  assert_locked_banks_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.locked |=> ($stable(selQ) && $stable(codeQ)));

endmodule

// File: rtl/pinmux_xbar.sv
module pinmux_xbar
  import pinmux_pkg::*;
#(
  parameter int                       NUM_PINS       = 22,
  parameter int                       NUM_PERIPH_IN  = 8,
  parameter int                       NUM_PERIPH_OUT = 12,
  parameter logic [NUM_PERIPH_IN-1:0] INACTIVE_LVL   = '1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [7:0]                wrAddr,
  input  logic [7:0]                wrData,
  input  logic [7:0]                rdAddr,
  output logic [7:0]                rdData,
  input  logic [NUM_PINS-1:0]       padIn,
  input  logic [NUM_PINS-1:0]       anaEn,
  input  logic [NUM_PINS-1:0]       gpioOut,
  input  logic [NUM_PINS-1:0]       gpioOe,
  input  logic [NUM_PINS-1:0]       altEn,
  input  logic [NUM_PINS-1:0]       altOut,
  input  logic [NUM_PINS-1:0]       altOe,
  input  logic [NUM_PERIPH_OUT-1:0] periphOut,
  input  logic [NUM_PERIPH_OUT-1:0] periphOe,
  output logic [NUM_PERIPH_IN-1:0]  periphIn,
  output logic [NUM_PINS-1:0]       padOut,
  output logic [NUM_PINS-1:0]       padOe
);
  // select width leaves room for one "unmapped" value above the last pad
  localparam int SEL_W  = $clog2(NUM_PINS + 1);
  localparam int CODE_W = $clog2(NUM_PERIPH_OUT + 1);

  map_strobe_t strobe;

  pinmux_ctrl #(
    .NUM_PINS     (NUM_PINS),
    .NUM_PERIPH_IN(NUM_PERIPH_IN)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .strobe(strobe)
  );

  pinmux_regs #(
    .NUM_PINS      (NUM_PINS),
    .NUM_PERIPH_IN (NUM_PERIPH_IN),
    .NUM_PERIPH_OUT(NUM_PERIPH_OUT),
    .SEL_W         (SEL_W),
    .CODE_W        (CODE_W),
    .INACTIVE_LVL  (INACTIVE_LVL)
  ) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .padIn    (padIn),
    .anaEn    (anaEn),
    .gpioOut  (gpioOut),
    .gpioOe   (gpioOe),
    .altEn    (altEn),
    .altOut   (altOut),
    .altOe    (altOe),
    .periphOut(periphOut),
    .periphOe (periphOe),
    .periphIn (periphIn),
    .padOut   (padOut),
    .padOe    (padOe)
  );

endmodule

// File: tb/test_pinmux_xbar.sv
`timescale 1ns/1ps
module test_pinmux_xbar;
  localparam int NP = 22;
  localparam int NI = 8;
  localparam int NO = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [7:0]    wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic [7:0]    rdAddr = '0;
  logic [7:0]    rdData;
  logic [NP-1:0] padIn = '0, anaEn = '0, gpioOut = '0, gpioOe = '0;
  logic [NP-1:0] altEn = '0, altOut = '0, altOe = '0;
  logic [NO-1:0] periphOut = '0, periphOe = '0;
  logic [NI-1:0] periphIn;
  logic [NP-1:0] padOut, padOe;

  pinmux_xbar i_pinmux_xbar (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .padIn(padIn), .anaEn(anaEn),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .altEn(altEn), .altOut(altOut),
    .altOe(altOe), .periphOut(periphOut), .periphOe(periphOe),
    .periphIn(periphIn), .padOut(padOut), .padOe(padOe)
  );

  always #2.5 clk = ~clk;

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  bit autoRd = 1;
  int anaMode = 0;  // 0 sparse, 1 all analog, 2 none

  // reference model state
  int mSel[NI];
  int mCode[NP];
  bit mLock;
  int mKey;

  function automatic void modelReset();
    for (int i = 0; i < NI; i++) mSel[i] = 31;
    for (int p = 0; p < NP; p++) mCode[p] = 0;
    mLock = 0;
    mKey = 0;
  endfunction

  function automatic void modelTick();
    int nk;
    int a;
    if (!rstN) begin
      modelReset();
      return;
    end
    a = int'(wrAddr);
    nk = 0;
    if (wrEn && a == 1) begin
      if (wrData == 8'h55) nk = 1;
      else if (wrData == 8'hAA && mKey == 1) nk = 2;
    end
    if (wrEn && a == 0) begin
      if (wrData[0]) mLock = 1;
      else if (mKey == 2) mLock = 0;
    end else if (wrEn && !mLock) begin
      if (a >= 32 && a < 32 + NI) mSel[a - 32] = int'(wrData) % 32;
      if (a >= 64 && a < 64 + NP) mCode[a - 64] = int'(wrData) % 16;
    end
    mKey = nk;
  endfunction

  function automatic logic [7:0] expRd();
    int a;
    a = int'(rdAddr);
    if (a == 0) return {7'd0, mLock};
    if (a >= 32 && a < 32 + NI) return 8'(mSel[a - 32]);
    if (a >= 64 && a < 64 + NP) return 8'(mCode[a - 64]);
    return 8'd0;
  endfunction

  function automatic logic [NI-1:0] expIn();
    logic [NI-1:0] r;
    for (int i = 0; i < NI; i++) begin
      if (mSel[i] < NP) r[i] = padIn[mSel[i]] && !anaEn[mSel[i]];
      else r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic void expPads(output logic [NP-1:0] o, output logic [NP-1:0] e);
    for (int p = 0; p < NP; p++) begin
      if (anaEn[p]) begin
        o[p] = 0; e[p] = 0;
      end else if (mCode[p] >= 1 && mCode[p] <= NO) begin
        o[p] = periphOut[mCode[p] - 1]; e[p] = periphOe[mCode[p] - 1];
      end else if (altEn[p]) begin
        o[p] = altOut[p]; e[p] = altOe[p];
      end else begin
        o[p] = gpioOut[p]; e[p] = gpioOe[p];
      end
    end
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [NP-1:0] eo, ee;
    expPads(eo, ee);
    chk(tag, "rdData", 32'(rdData), 32'(expRd()));
    chk(tag, "periphIn", 32'(periphIn), 32'(expIn()));
    chk(tag, "padOut", 32'(padOut), 32'(eo));
    chk(tag, "padOe", 32'(padOe), 32'(ee));
  endtask

  function automatic logic [7:0] pickAddr();
    case ($urandom % 5)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'(32 + $urandom % NI);
      3: return 8'(64 + $urandom % NP);
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic step(input string tag);
    padIn = NP'($urandom); gpioOut = NP'($urandom); gpioOe = NP'($urandom);
    altEn = NP'($urandom); altOut = NP'($urandom); altOe = NP'($urandom);
    periphOut = NO'($urandom); periphOe = NO'($urandom);
    case (anaMode)
      1: anaEn = '1;
      2: anaEn = '0;
      default: anaEn = NP'($urandom & $urandom & $urandom);
    endcase
    if (autoRd) rdAddr = pickAddr();
    #1;
    compareAll(tag);
    @(posedge clk);
    modelTick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    wrEn = 1; wrAddr = a; wrData = d;
    step(tag);
    wrEn = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic readAt(input logic [7:0] a, input string tag);
    autoRd = 0; rdAddr = a;
    step(tag);
    autoRd = 1;
  endtask

  initial begin
    modelReset();
    @(negedge clk);
    idle(3, "R1 in reset");
    rstN = 1;
    // R1: reset values of all registers
    readAt(8'h00, "R1 lock");
    for (int i = 0; i < NI; i++) readAt(8'(32 + i), "R1 select");
    for (int p = 0; p < NP; p++) readAt(8'(64 + p), "R1 code");
    idle(5, "R4 R6 unmapped after reset");

    // R2 R3: distinct pads per input, then shared pads
    for (int i = 0; i < NI; i++) wr(8'(32 + i), 8'((i * 3 + 1) % NP), "R2 R3 select write");
    for (int i = 0; i < NI; i++) readAt(8'(32 + i), "R2 select readback");
    idle(30, "R3 routing distinct");
    wr(8'h20, 8'd21, "R3 last pad"); wr(8'h21, 8'd21, "R3 shared pad");
    wr(8'h22, 8'd0, "R3 pad zero");
    idle(20, "R3 routing shared");
    // R4: out-of-range selects and truncation of wide data
    wr(8'h20, 8'd22, "R4 select 22"); wr(8'h21, 8'd31, "R4 select 31");
    wr(8'h22, 8'hE5, "R2 select truncation");
    idle(20, "R4 inactive level");

    // R5 R6: every code on some pad
    for (int p = 0; p < NP; p++) wr(8'(64 + p), 8'(p % 13), "R5 code write");
    for (int p = 0; p < NP; p++) readAt(8'(64 + p), "R2 code readback");
    anaMode = 2; idle(30, "R5 R6 priority no analog"); anaMode = 0;
    wr(8'h40, 8'd13, "R6 code 13"); wr(8'h41, 8'd15, "R6 code 15");
    wr(8'h42, 8'h1F, "R6 code truncated to 15"); wr(8'h43, 8'd12, "R5 last code");
    readAt(8'h01, "R2 key reads zero");
    anaMode = 2; idle(30, "R6 fallback"); anaMode = 0;
    // R7: analog overrides everything
    anaMode = 1; idle(10, "R7 all analog"); anaMode = 0;
    idle(30, "R7 sparse analog");

    // R8: locked writes ignored
    wr(8'h00, 8'h01, "R8 set lock");
    readAt(8'h00, "R8 lock reads 1");
    wr(8'h20, 8'd5, "R8 locked select write"); wr(8'h41, 8'd3, "R8 locked code write");
    wr(8'h00, 8'h00, "R9 clear without key");
    readAt(8'h20, "R8 select held"); readAt(8'h41, "R8 code held");
    readAt(8'h00, "R9 still locked");
    // R9: broken sequences
    wr(8'h01, 8'h55, "R9 gap1"); idle(1, "R9 gap1"); wr(8'h01, 8'hAA, "R9 gap1"); wr(8'h00, 8'h00, "R9 gap1");
    readAt(8'h00, "R9 gap before second key");
    wr(8'h01, 8'h55, "R9 gap2"); wr(8'h01, 8'hAA, "R9 gap2"); idle(1, "R9 gap2"); wr(8'h00, 8'h00, "R9 gap2");
    readAt(8'h00, "R9 gap before clear");
    wr(8'h01, 8'hAA, "R9 swap"); wr(8'h01, 8'h55, "R9 swap"); wr(8'h00, 8'h00, "R9 swap");
    readAt(8'h00, "R9 swapped keys");
    wr(8'h01, 8'h55, "R9 good"); wr(8'h01, 8'hAA, "R9 good"); wr(8'h00, 8'h00, "R9 good");
    readAt(8'h00, "R9 unlocked");
    wr(8'h20, 8'd7, "R2 write after unlock"); readAt(8'h20, "R2 write after unlock");

    // mixed random traffic with periodic unlock
    for (int k = 0; k < 3000; k++) begin
      if (k % 250 == 0) begin
        wr(8'h01, 8'h55, "R9 random unlock"); wr(8'h01, 8'hAA, "R9 random unlock");
        wr(8'h00, 8'h00, "R9 random unlock");
      end
      if ($urandom % 3 == 0) wr(pickAddr(), 8'($urandom), "R2 R3 R5 R8 random");
      else step("R3 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule